// File: doc/BRIEF.md
# I2C Byte-Addressed Serial EEPROM Slave

This block is an I2C target that behaves like a small serial EEPROM built from flip-flops. It watches the open-drain SCL and SDA lines. It samples both through synchronisers on the system clock. It recognises start and stop conditions. It answers only to the 7-bit address formed by the fixed device code `1010` followed by three strap inputs.

A write transaction carries a word-address byte first. Every byte after it is stored at the current pointer. The pointer then advances, but only its low bits advance, so a burst that runs past the page end folds back to the page start. A read transaction returns bytes from the current pointer, MSB first. The pointer advances across the whole array and wraps from the top address to zero. Sending a word address and then a repeated start with the read direction performs a random read. A high write-protect input keeps the array unchanged, while bytes are still acknowledged.

The SDA output is a pull-down request: `1` means the slave drives the line low. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the slave releases SDA, every array byte reads as 0x00 and the word pointer is 0.
- R2: A first byte after start whose bits 7..1 equal `1010` followed by strap bits 2..0 is acknowledged by a low SDA during the ninth SCL clock.
- R3: A first byte with any other address gets no acknowledge. The slave leaves SDA released and stores nothing until the next start.
- R4: With direction bit 0 = 0, the next byte loads the word pointer. Each later byte is acknowledged, stored at the pointer, and the pointer then advances by one.
- R5: During a write the pointer advances only within its 8-byte page, so byte 9 of a burst overwrites byte 1.
- R6: While the write-protect input is high, data bytes are acknowledged and the pointer advances, but the array is not changed.
- R7: With direction bit 0 = 1, the slave shifts out the byte at the pointer MSB first and changes SDA only while SCL is low. A read right after start begins at the pointer left by the previous access.
- R8: After each byte read the pointer advances by one, wrapping from 0xFF to 0x00. A master ACK makes the slave send the next byte.
- R9: After a master NACK the slave releases SDA and drives nothing until the next start.
- R10: A word-address write followed by a repeated start and a read address returns data from that word address.
- R11: A start condition (SDA falling while SCL is high) restarts byte framing at the address byte, even in the middle of a byte. A stop (SDA rising while SCL is high) returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| strap_i | input | 3 | Low three bits of the slave address |
| wp_i | input | 1 | Write protect, high blocks storage |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK or data 0) |

## Verification
The bench targets the page fold in a burst of ten bytes starting mid-page. A design that carried into the upper address bits would write into the next page, and the readback would show stale bytes where the folded data belongs. It also targets the read pointer crossing 0xFF. A design that applied the page fold to reads would return byte 0xF8 instead of 0x00. A wrong strap value must get no acknowledge, and any bytes sent after it must leave the array untouched; a design that latched them would corrupt a later readback. A start issued after three bits of a byte must reframe the slave so that the following address is acknowledged, and after a master NACK the line must stay high through further SCL clocks.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES sync flops plus one history flop for edge detection; idle bus is high
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic start_w, stop_w;

  state_e              state_q;
  logic [3:0]          bit_cnt_q;
  logic [7:0]          shift_q;
  logic [7:0]          tx_q;
  logic [ADDR_W-1:0]   word_addr_q;
  logic                rw_q;
  logic                mack_q;
  logic                pull_q;

  logic                mem_we;
  logic [7:0]          mem_rdata;
  logic                dev_match;
  logic [PAGE_W-1:0]   page_lo_next;
  logic [ADDR_W-1:0]   page_next;
  logic [ADDR_W-1:0]   full_next;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(scl_i),
    .q_o   (scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sda_i),
    .q_o   (sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_w = sda_fall & scl_s;
  assign stop_w  = sda_rise & scl_s;

  assign dev_match    = (shift_q[7:1] == {DEV_CODE, strap_i});
  assign page_lo_next = word_addr_q[PAGE_W-1:0] + PAGE_W'(1);
  assign page_next    = {word_addr_q[ADDR_W-1:PAGE_W], page_lo_next};
  assign full_next    = word_addr_q + ADDR_W'(1);

  // store on the falling edge that ends the 8th data bit
  assign mem_we = (state_q == ST_WDATA) && scl_fall && (bit_cnt_q == 4'd8)
                  && !wp_i && !start_w && !stop_w;

  i2c_ee_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .addr_i (word_addr_q),
    .wdata_i(shift_q),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      tx_q        <= '0;
      word_addr_q <= '0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      pull_q      <= 1'b0;
    end else if (start_w) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      pull_q    <= 1'b0;
    end else if (stop_w) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      pull_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            shift_q   <= {shift_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            bit_cnt_q <= 4'd9;
            if (state_q == ST_DEV) begin
              if (dev_match) begin
                pull_q <= 1'b1;
                rw_q   <= shift_q[0];
              end else begin
                state_q   <= ST_IDLE;
                bit_cnt_q <= '0;
              end
            end else begin
              pull_q <= 1'b1;
              if (state_q == ST_WADDR) word_addr_q <= shift_q[ADDR_W-1:0];
              else                     word_addr_q <= page_next;
            end
          end else if (scl_fall && bit_cnt_q == 4'd9) begin
            pull_q    <= 1'b0;
            bit_cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                tx_q    <= mem_rdata;
                pull_q  <= ~mem_rdata[7];
              end else begin
                state_q <= ST_WADDR;
              end
            end else begin
              state_q <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_rise && bit_cnt_q == 4'd8) begin
            mack_q    <= ~sda_s;
            bit_cnt_q <= 4'd9;
          end else if (scl_fall && bit_cnt_q != 4'd0 && bit_cnt_q < 4'd8) begin
            pull_q <= ~tx_q[6];
            tx_q   <= {tx_q[6:0], 1'b0};
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            pull_q      <= 1'b0;
            word_addr_q <= full_next;
          end else if (scl_fall && bit_cnt_q == 4'd9) begin
            bit_cnt_q <= '0;
            if (mack_q) begin
              tx_q   <= mem_rdata;
              pull_q <= ~mem_rdata[7];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_pull_i,
  input logic              scl_fall_i,
  input logic              start_i,
  input state_e            state_i,
  input logic [3:0]        bit_cnt_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] word_addr_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_QUIET: assert (!sda_pull_i); // R1
  end

  AST_ACK_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> sda_pull_i); // R4

  AST_PAGE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> word_addr_i[ADDR_W-1:PAGE_W] == $past(word_addr_i[ADDR_W-1:PAGE_W])); // R5

  AST_SDA_MOVES_ON_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_i) |-> $past(scl_fall_i)); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> !sda_pull_i); // R9

  AST_START_REFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_i == ST_DEV && bit_cnt_i == 4'd0); // R11

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= 4'd9); // R11
endmodule

bind i2c_eeprom_slave i2c_ee_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_pull_i (sda_pull_o),
  .scl_fall_i (scl_fall),
  .start_i    (start_w),
  .state_i    (state_q),
  .bit_cnt_i  (bit_cnt_q),
  .mem_we_i   (mem_we),
  .word_addr_i(word_addr_q)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int Q = 10;  // system clocks per quarter SCL period
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_pull = 1'b0;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_line;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] ptr = 8'h00;

  always #2 clk = ~clk;

  assign sda_line = ~(m_sda_pull | sda_pull);

  i2c_eeprom_slave u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .strap_i   (STRAP),
    .wp_i      (wp),
    .sda_pull_o(sda_pull)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda_pull = ~b;
    qw(); m_scl = 1'b1;
    qw(); s = sda_line;
    qw(); m_scl = 1'b0;
    qw();
  endtask

  task automatic bus_start();
    m_sda_pull = 1'b0;
    qw(); m_scl = 1'b1;
    qw(); m_sda_pull = 1'b1;
    qw(); m_scl = 1'b0;
    qw();
  endtask

  task automatic bus_stop();
    m_sda_pull = 1'b1;
    qw(); m_scl = 1'b1;
    qw(); m_sda_pull = 1'b0;
    qw();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    bit_io(~mack, s);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] st, input logic rw);
    return {4'b1010, st, rw};
  endfunction

  function automatic logic [7:0] page_inc(input logic [7:0] a);
    return {a[7:3], a[2:0] + 3'd1};
  endfunction

  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] v0, input string req);
    logic ack;
    bus_start();
    wr_byte(dev(STRAP, 1'b0), ack);
    chk(ack, "R2 write address ack", ack, 1);
    wr_byte(a, ack);
    chk(ack, "R4 word address ack", ack, 1);
    ptr = a;
    for (int i = 0; i < n; i++) begin
      wr_byte(v0 + 8'(i), ack);
      chk(ack, req, ack, 1);
      if (!wp) exp_mem[ptr] = v0 + 8'(i);
      ptr = page_inc(ptr);
    end
    bus_stop();
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk(d == exp_mem[ptr], req, d, exp_mem[ptr]);
      ptr = ptr + 8'd1;
    end
  endtask

  task automatic read_random(input logic [7:0] a, input int n, input string req);
    logic ack;
    bus_start();
    wr_byte(dev(STRAP, 1'b0), ack);
    chk(ack, "R10 dev ack", ack, 1);
    wr_byte(a, ack);
    chk(ack, "R10 word ack", ack, 1);
    ptr = a;
    bus_start();
    wr_byte(dev(STRAP, 1'b1), ack);
    chk(ack, "R2 read address ack", ack, 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  task automatic read_current(input int n, input string req);
    logic ack;
    bus_start();
    wr_byte(dev(STRAP, 1'b1), ack);
    chk(ack, "R2 read address ack", ack, 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  // R1 R7: reset state and first current read
  task automatic t_reset();
    chk(sda_pull == 1'b0, "R1 sda released after reset", sda_pull, 0);
    read_current(2, "R1 R7 reset content via current read");
  endtask

  // R4 R10 R8: burst write then random read back
  task automatic t_write_read();
    write_seq(8'h10, 4, 8'hC3, "R4 data ack");
    read_current(1, "R7 current read after write");
    read_random(8'h10, 4, "R10 R8 random read back");
  endtask

  // R3: wrong strap gets no ack and nothing is stored
  task automatic t_mismatch();
    logic ack;
    bus_start();
    wr_byte(dev(3'b011, 1'b0), ack);
    chk(!ack, "R3 no ack on wrong address", ack, 0);
    wr_byte(8'h10, ack);
    chk(!ack, "R3 no ack on following byte", ack, 0);
    wr_byte(8'h77, ack);
    chk(!ack, "R3 no ack on data", ack, 0);
    bus_stop();
    read_random(8'h10, 2, "R3 array unchanged");
  endtask

  // R5: ten bytes from 0x23 fold inside page 0x20..0x27
  task automatic t_page_wrap();
    write_seq(8'h23, 10, 8'h40, "R5 burst ack");
    read_random(8'h20, 8, "R5 page fold readback");
    read_random(8'h28, 1, "R5 next page untouched");
  endtask

  // R6: protected write acked but not stored
  task automatic t_wp();
    wp = 1'b1;
    write_seq(8'h60, 2, 8'h5A, "R6 protected data ack");
    wp = 1'b0;
    read_random(8'h60, 2, "R6 protected bytes unchanged");
  endtask

  // R8: read crosses 0xFF to 0x00
  task automatic t_seq_wrap();
    write_seq(8'hFE, 2, 8'hE1, "R4 data ack");
    write_seq(8'h00, 1, 8'h99, "R4 data ack");
    read_random(8'hFE, 3, "R8 read wraps to 0x00");
    read_current(2, "R7 current read continues");
  endtask

  // R9: after master NACK the line stays released
  task automatic t_nack_release();
    logic ack;
    logic s;
    bus_start();
    wr_byte(dev(STRAP, 1'b1), ack);
    chk(ack, "R2 read address ack", ack, 1);
    read_bytes(1, "R9 single read");
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, s);
      chk(s == 1'b1, "R9 sda released after nack", s, 1);
    end
    bus_stop();
  endtask

  // R11: start mid byte reframes at address byte
  task automatic t_reframe();
    logic ack;
    logic s;
    bus_start();
    bit_io(1'b1, s);
    bit_io(1'b0, s);
    bit_io(1'b1, s);
    bus_start();
    wr_byte(dev(STRAP, 1'b0), ack);
    chk(ack, "R11 ack after restart", ack, 1);
    wr_byte(8'h50, ack);
    wr_byte(8'h3C, ack);
    chk(ack, "R11 data ack", ack, 1);
    bus_stop();
    exp_mem[8'h50] = 8'h3C;
    read_random(8'h50, 1, "R11 stored after reframe");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_mismatch();
    t_page_wrap();
    t_wp();
    t_seq_wrap();
    t_nack_release();
    t_reframe();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=0x0 exp=0x1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule